// File: doc/BRIEF.md
# IDE Task-File Register Bridge

This block puts an ATA-style task file on a simple CPU register bus. Software writes the byte-wide registers that describe a drive command: the feature, the sector count, three LBA bytes, the device select, the command opcode and device control. Software then reads back status, error and disc-status bytes that the drive side supplies. While the drive reports itself busy, writes to the command-setup registers are dropped. An accepted command write raises busy, clears the pending drive interrupt and emits a one-cycle issue strobe that carries the opcode. The drive's command logic sits behind that strobe.

The two status addresses behave differently. Reading the command address acknowledges the drive interrupt. Reading the alternate-status address leaves the interrupt alone, and writing that address loads device control. The data address does not hold any storage: each access there is passed through as a PIO read or write strobe to the data path. Any address above the task file selects a small scratch array.

Word addresses: 0 data, 1 feature (write) / error (read), 2 count, 3 LBA0 (write) / disc status (read), 4 LBA1, 5 LBA2, 6 device, 7 command (write) / status (read), 8 device control (write) / alternate status (read), 9 to 9+SCR_N-1 scratch.

Top module: `ide_taskfile_bridge`

## Requirements
- R1: After reset every stored byte, the status register, `irq` and `cmd_valid` are 0.
- R2: A write to address 1, 2, 3, 4, 5 or 6 stores `bus_wdata[7:0]` only when status bit 7 (busy) is 0, and is dropped when it is 1.
- R3: A write to address 8 loads device control whatever the busy state. A read of address 8 returns status and leaves `irq` unchanged.
- R4: A read of address 7 returns status, and `irq` is 0 from the following cycle.
- R5: A write to address 7 while not busy makes `cmd_valid` high for exactly the next cycle, with `cmd_opcode` equal to the written low byte, and clears `irq`. A write while busy issues nothing.
- R6: A read of address 1 returns `dev_error` and a read of address 3 returns `dev_disc`. Reads of addresses 2, 4, 5 and 6 return the stored bytes. Bytes are zero-extended to the bus width.
- R7: An access to address 0 drives `pio_wr` or `pio_rd` in the same cycle, with `pio_wdata` equal to `bus_wdata`. A read there returns `pio_rdata`.
- R8: Scratch addresses read back the last byte written to them. Unused addresses read 0.
- R9: `dev_done` sets the sticky `irq`. If a clear (from R4 or R5) falls in the same cycle, the clear wins.
- R10: `dev_status_we` loads status from `dev_status_in`. An accepted command write in the same cycle still leaves bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data (combinational) |
| dev_error | input | 8 | Error byte from the drive |
| dev_disc | input | 8 | Disc-status byte from the drive |
| dev_status_we | input | 1 | Status load strobe from the drive |
| dev_status_in | input | 8 | New status value |
| dev_done | input | 1 | Drive event pulse that raises the interrupt |
| pio_rdata | input | BUS_W | Data-path read value |
| pio_wr | output | 1 | Data-port write strobe |
| pio_rd | output | 1 | Data-port read strobe |
| pio_wdata | output | BUS_W | Data-port write value |
| tf_feature | output | 8 | Feature register |
| tf_count | output | 8 | Count register |
| tf_lba0 | output | 8 | LBA byte 0 |
| tf_lba1 | output | 8 | LBA byte 1 |
| tf_lba2 | output | 8 | LBA byte 2 |
| tf_device | output | 8 | Device register |
| tf_devctl | output | 8 | Device-control register |
| tf_status | output | 8 | Status register |
| cmd_valid | output | 1 | One-cycle command issue strobe |
| cmd_opcode | output | 8 | Issued opcode |
| irq | output | 1 | Sticky drive interrupt |

## Verification
If the busy bit is stuck or its polarity is wrong, the next setup write is either kept when it should be dropped, or dropped when it should be kept. The mismatch shows on the `tf_*` outputs one cycle after that write. A misdecoded read view, for example stored feature returned instead of error, shows on `bus_rdata` in the same cycle as the read. A broken interrupt flag shows on `irq` one cycle after the event: a sticky bit that the alternate read clears, a command read that fails to clear it, or a done pulse that overrides a simultaneous clear.

// File: rtl/ide_tf_pkg.sv
package ide_tf_pkg;
  localparam int A_DATA  = 0;
  localparam int A_FEAT  = 1;
  localparam int A_COUNT = 2;
  localparam int A_LBA0  = 3;
  localparam int A_LBA1  = 4;
  localparam int A_LBA2  = 5;
  localparam int A_DEV   = 6;
  localparam int A_CMD   = 7;
  localparam int A_ALT   = 8;
  localparam int A_SCR   = 9;
  localparam int BSY_BIT = 7;

  typedef struct packed {
    logic data;
    logic feat;
    logic count;
    logic lba0;
    logic lba1;
    logic lba2;
    logic dev;
    logic cmd;
    logic alt;
    logic scr;
  } tf_hit_t;

  function automatic tf_hit_t decode_addr(int unsigned a, int unsigned scr_n);
    tf_hit_t h;
    h.data  = (a == A_DATA);
    h.feat  = (a == A_FEAT);
    h.count = (a == A_COUNT);
    h.lba0  = (a == A_LBA0);
    h.lba1  = (a == A_LBA1);
    h.lba2  = (a == A_LBA2);
    h.dev   = (a == A_DEV);
    h.cmd   = (a == A_CMD);
    h.alt   = (a == A_ALT);
    h.scr   = (a >= A_SCR) && (a < A_SCR + scr_n);
    return h;
  endfunction

  function automatic logic [7:0] next_status(logic [7:0] q, logic load,
                                             logic [7:0] din, logic cmd_acc);
    logic [7:0] n;
    n = load ? din : q;
    if (cmd_acc) n[BSY_BIT] = 1'b1;
    return n;
  endfunction

  function automatic logic next_irq(logic q, logic set, logic clr);
    return clr ? 1'b0 : (q | set);
  endfunction
endpackage

// File: rtl/tf_decode.sv
module tf_decode
  import ide_tf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int SCR_N  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output tf_hit_t           hit
);
  always_comb hit = decode_addr(int'(addr), SCR_N);
endmodule

// File: rtl/tf_regfile.sv
module tf_regfile #(
  parameter int SCR_N  = 4,
  parameter int SCR_IW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [6:0]            we,      // feat,count,lba0,lba1,lba2,dev,ctl
  input  logic                  scr_we,
  input  logic [SCR_IW-1:0]     scr_idx,
  input  logic [7:0]            wbyte,
  output logic [7:0]            feat_q,
  output logic [7:0]            count_q,
  output logic [7:0]            lba0_q,
  output logic [7:0]            lba1_q,
  output logic [7:0]            lba2_q,
  output logic [7:0]            dev_q,
  output logic [7:0]            ctl_q,
  output logic [SCR_N-1:0][7:0] scr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_q  <= '0;
      count_q <= '0;
      lba0_q  <= '0;
      lba1_q  <= '0;
      lba2_q  <= '0;
      dev_q   <= '0;
      ctl_q   <= '0;
    end else begin
      if (we[6]) feat_q  <= wbyte;
      if (we[5]) count_q <= wbyte;
      if (we[4]) lba0_q  <= wbyte;
      if (we[3]) lba1_q  <= wbyte;
      if (we[2]) lba2_q  <= wbyte;
      if (we[1]) dev_q   <= wbyte;
      if (we[0]) ctl_q   <= wbyte;
    end
  end

  for (genvar i = 0; i < SCR_N; i++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   scr_q[i] <= '0;
      else if (scr_we && (scr_idx == SCR_IW'(i)))   scr_q[i] <= wbyte;
    end
  end
endmodule

// File: rtl/tf_ctrl.sv
module tf_ctrl
  import ide_tf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_acc,
  input  logic       irq_clr,
  input  logic       dev_done,
  input  logic       dev_status_we,
  input  logic [7:0] dev_status_in,
  input  logic [7:0] wbyte,
  output logic [7:0] status_q,
  output logic       irq_q,
  output logic       cmd_valid_q,
  output logic [7:0] cmd_op_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q    <= '0;
      irq_q       <= 1'b0;
      cmd_valid_q <= 1'b0;
      cmd_op_q    <= '0;
    end else begin
      status_q    <= next_status(status_q, dev_status_we, dev_status_in, cmd_acc);
      irq_q       <= next_irq(irq_q, dev_done, irq_clr);
      cmd_valid_q <= cmd_acc;
      if (cmd_acc) cmd_op_q <= wbyte;
    end
  end
endmodule

// File: rtl/ide_taskfile_bridge.sv
module ide_taskfile_bridge
  import ide_tf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 32,
  parameter int SCR_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [7:0]        dev_error,
  input  logic [7:0]        dev_disc,
  input  logic              dev_status_we,
  input  logic [7:0]        dev_status_in,
  input  logic              dev_done,
  input  logic [BUS_W-1:0]  pio_rdata,
  output logic              pio_wr,
  output logic              pio_rd,
  output logic [BUS_W-1:0]  pio_wdata,
  output logic [7:0]        tf_feature,
  output logic [7:0]        tf_count,
  output logic [7:0]        tf_lba0,
  output logic [7:0]        tf_lba1,
  output logic [7:0]        tf_lba2,
  output logic [7:0]        tf_device,
  output logic [7:0]        tf_devctl,
  output logic [7:0]        tf_status,
  output logic              cmd_valid,
  output logic [7:0]        cmd_opcode,
  output logic              irq
);
  localparam int SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1;

  tf_hit_t                hit;
  logic                   wr_ok;     // busy bit clear
  logic                   cmd_acc;   // accepted command write
  logic                   irq_clr;   // interrupt acknowledge event
  logic [6:0]             tf_we;
  logic [7:0]             wbyte;
  logic [ADDR_W-1:0]      scr_off;
  logic [SCR_IW-1:0]      scr_idx;
  logic [SCR_N-1:0][7:0]  scr_q;
  logic [7:0]             rbyte;

  tf_decode #(.ADDR_W(ADDR_W), .SCR_N(SCR_N)) u_dec (
    .addr(bus_addr), .hit(hit)
  );

  assign wbyte   = bus_wdata[7:0];
  assign wr_ok   = ~tf_status[BSY_BIT];
  assign cmd_acc = bus_wr & hit.cmd & wr_ok;
  assign irq_clr = cmd_acc | (bus_rd & hit.cmd);
  assign tf_we   = {bus_wr & wr_ok & hit.feat,
                    bus_wr & wr_ok & hit.count,
                    bus_wr & wr_ok & hit.lba0,
                    bus_wr & wr_ok & hit.lba1,
                    bus_wr & wr_ok & hit.lba2,
                    bus_wr & wr_ok & hit.dev,
                    bus_wr & hit.alt};
  assign scr_off = bus_addr - ADDR_W'(A_SCR);
  assign scr_idx = scr_off[SCR_IW-1:0];

  assign pio_wr    = bus_wr & hit.data;
  assign pio_rd    = bus_rd & hit.data;
  assign pio_wdata = bus_wdata;

  tf_regfile #(.SCR_N(SCR_N), .SCR_IW(SCR_IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(tf_we), .scr_we(bus_wr & hit.scr),
    .scr_idx(scr_idx), .wbyte(wbyte),
    .feat_q(tf_feature), .count_q(tf_count), .lba0_q(tf_lba0),
    .lba1_q(tf_lba1), .lba2_q(tf_lba2), .dev_q(tf_device),
    .ctl_q(tf_devctl), .scr_q(scr_q)
  );

  tf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_acc(cmd_acc), .irq_clr(irq_clr),
    .dev_done(dev_done), .dev_status_we(dev_status_we),
    .dev_status_in(dev_status_in), .wbyte(wbyte),
    .status_q(tf_status), .irq_q(irq),
    .cmd_valid_q(cmd_valid), .cmd_op_q(cmd_opcode)
  );

  always_comb begin
    rbyte = '0;
    unique case (1'b1)
      hit.feat:          rbyte = dev_error;
      hit.count:         rbyte = tf_count;
      hit.lba0:          rbyte = dev_disc;
      hit.lba1:          rbyte = tf_lba1;
      hit.lba2:          rbyte = tf_lba2;
      hit.dev:           rbyte = tf_device;
      hit.cmd, hit.alt:  rbyte = tf_status;
      hit.scr:           rbyte = scr_q[scr_idx];
      default:           rbyte = '0;
    endcase
    bus_rdata = hit.data ? pio_rdata : {{(BUS_W-8){1'b0}}, rbyte};
  end
endmodule

// File: rtl/ide_tf_checker.sv
module ide_tf_checker
  import ide_tf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              dev_done,
  input logic              cmd_acc,
  input logic              irq_clr,
  input logic              irq,
  input logic              cmd_valid,
  input logic [7:0]        cmd_opcode,
  input logic [7:0]        tf_status,
  input logic [7:0]        tf_count,
  input logic [7:0]        tf_devctl
);
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R5
  AST_CMD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |=> (cmd_valid && cmd_opcode == $past(bus_wdata[7:0]))); // R5
  AST_CMD_SETS_BSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> tf_status[BSY_BIT]); // R10
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && tf_status[BSY_BIT] && bus_addr == ADDR_W'(A_COUNT)) |=> $stable(tf_count)); // R2
  AST_DEVCTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_ALT)) |=> tf_devctl == $past(bus_wdata[7:0])); // R3
  AST_ALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && bus_rd && bus_addr == ADDR_W'(A_ALT) && !irq_clr) |=> irq); // R3
  AST_CMDREAD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(A_CMD)) |=> !irq); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && irq_clr) |=> !irq); // R9
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && !irq_clr) |=> irq); // R9
endmodule

bind ide_taskfile_bridge ide_tf_checker #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dev_done(dev_done),
  .cmd_acc(cmd_acc), .irq_clr(irq_clr), .irq(irq), .cmd_valid(cmd_valid),
  .cmd_opcode(cmd_opcode), .tf_status(tf_status), .tf_count(tf_count),
  .tf_devctl(tf_devctl)
);

// File: tb/ide_taskfile_bridge_test.sv
module ide_taskfile_bridge_test;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;
  localparam int SCR_N  = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [BUS_W-1:0] bus_wdata = '0, bus_rdata, pio_rdata = '0, pio_wdata;
  logic [7:0] dev_error = '0, dev_disc = '0, dev_status_in = '0;
  logic dev_status_we = 0, dev_done = 0;
  logic pio_wr, pio_rd, cmd_valid, irq;
  logic [7:0] tf_feature, tf_count, tf_lba0, tf_lba1, tf_lba2, tf_device;
  logic [7:0] tf_devctl, tf_status, cmd_opcode;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [7:0] m_feat, m_cnt, m_l0, m_l1, m_l2, m_dev, m_ctl, m_stat;
  logic [7:0] m_scr [SCR_N];
  bit m_irq;

  always #(CLK_P/2) clk = ~clk;

  ide_taskfile_bridge #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .SCR_N(SCR_N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_error(dev_error), .dev_disc(dev_disc), .dev_status_we(dev_status_we),
    .dev_status_in(dev_status_in), .dev_done(dev_done), .pio_rdata(pio_rdata),
    .pio_wr(pio_wr), .pio_rd(pio_rd), .pio_wdata(pio_wdata),
    .tf_feature(tf_feature), .tf_count(tf_count), .tf_lba0(tf_lba0),
    .tf_lba1(tf_lba1), .tf_lba2(tf_lba2), .tf_device(tf_device),
    .tf_devctl(tf_devctl), .tf_status(tf_status), .cmd_valid(cmd_valid),
    .cmd_opcode(cmd_opcode), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench view of each address's read value
  function automatic logic [31:0] exp_read(int a);
    case (a)
      0: return pio_rdata;
      1: return {24'd0, dev_error};
      2: return {24'd0, m_cnt};
      3: return {24'd0, dev_disc};
      4: return {24'd0, m_l1};
      5: return {24'd0, m_l2};
      6: return {24'd0, m_dev};
      7, 8: return {24'd0, m_stat};
      default: return (a >= 9 && a < 9 + SCR_N) ? {24'd0, m_scr[a-9]} : 32'd0;
    endcase
  endfunction

  function automatic string req_of(int a);
    case (a)
      0: return "R7";
      1, 2, 3, 4, 5, 6: return "R6";
      7: return "R4";
      8: return "R3";
      default: return "R8";
    endcase
  endfunction

  task automatic cmp_regs(input string tag);
    chk(tf_feature == m_feat, tag, tf_feature, m_feat);
    chk(tf_count == m_cnt, tag, tf_count, m_cnt);
    chk(tf_lba0 == m_l0, tag, tf_lba0, m_l0);
    chk(tf_lba1 == m_l1, tag, tf_lba1, m_l1);
    chk(tf_lba2 == m_l2, tag, tf_lba2, m_l2);
    chk(tf_device == m_dev, tag, tf_device, m_dev);
    chk(tf_devctl == m_ctl, "R3", tf_devctl, m_ctl);
    chk(tf_status == m_stat, "R10", tf_status, m_stat);
    chk(irq == m_irq, "R9", irq, m_irq);
  endtask

  task automatic do_wr(input int a, input logic [31:0] d);
    bit busy = m_stat[7];
    bit acc = (a == 7) && !busy;
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1;
    #1;
    if (a == 0) begin
      chk(pio_wr == 1'b1, "R7", pio_wr, 1);
      chk(pio_wdata == d, "R7", pio_wdata, d);
    end else chk(pio_wr == 1'b0, "R7", pio_wr, 0);
    @(negedge clk);
    bus_wr = 0;
    case (a)
      1: if (!busy) m_feat = d[7:0];
      2: if (!busy) m_cnt  = d[7:0];
      3: if (!busy) m_l0   = d[7:0];
      4: if (!busy) m_l1   = d[7:0];
      5: if (!busy) m_l2   = d[7:0];
      6: if (!busy) m_dev  = d[7:0];
      7: if (acc) begin m_stat[7] = 1'b1; m_irq = 0; end
      8: m_ctl = d[7:0];
      default: if (a >= 9 && a < 9 + SCR_N) m_scr[a-9] = d[7:0];
    endcase
    chk(cmd_valid == acc, "R5", cmd_valid, acc);
    if (acc) begin
      chk(cmd_opcode == d[7:0], "R5", cmd_opcode, d[7:0]);
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R5", cmd_valid, 0);
    end
    cmp_regs("R2");
  endtask

  task automatic do_rd(input int a);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_rd = 1;
    #1;
    chk(bus_rdata == exp_read(a), req_of(a), bus_rdata, exp_read(a));
    chk(pio_rd == (a == 0), "R7", pio_rd, (a == 0));
    @(negedge clk);
    bus_rd = 0;
    if (a == 7) m_irq = 0;
    chk(irq == m_irq, (a == 7) ? "R4" : "R3", irq, m_irq);
  endtask

  task automatic dev_evt(input bit done, input bit swe, input logic [7:0] sv);
    @(negedge clk);
    dev_done = done; dev_status_we = swe; dev_status_in = sv;
    @(negedge clk);
    dev_done = 0; dev_status_we = 0;
    if (swe) m_stat = sv;
    if (done) m_irq = 1;
    chk(irq == m_irq, "R9", irq, m_irq);
    chk(tf_status == m_stat, "R10", tf_status, m_stat);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd5150);
    m_feat = 0; m_cnt = 0; m_l0 = 0; m_l1 = 0; m_l2 = 0; m_dev = 0;
    m_ctl = 0; m_stat = 0; m_irq = 0;
    for (int i = 0; i < SCR_N; i++) m_scr[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(cmd_valid == 0, "R1", cmd_valid, 0);
    cmp_regs("R1");
    do_rd(8);

    // Directed: setup writes while idle, then command
    do_wr(2, 32'hABCD_1234);
    do_wr(3, 32'h0000_0055);
    do_wr(1, 32'h0000_0077);
    dev_error = 8'h3C; dev_disc = 8'h96;
    do_rd(1); // R6 error view, not 0x77
    do_rd(3); // R6 disc view, not 0x55
    dev_evt(1, 0, 8'h00);     // irq set
    do_wr(7, 32'h0000_00A0);  // R5 accepted, irq cleared, BSY
    do_wr(2, 32'h0000_0011);  // R2 dropped while busy
    do_wr(7, 32'h0000_00EC);  // R5 no issue while busy
    do_wr(8, 32'h0000_0002);  // R3 devctl even while busy
    dev_evt(1, 0, 8'h00);
    do_rd(8);                 // R3 irq stays
    do_rd(7);                 // R4 clears
    // R9 clear wins: done with command-address read
    dev_evt(1, 1, 8'h50);
    @(negedge clk);
    dev_done = 1; bus_rd = 1; bus_addr = ADDR_W'(7);
    @(negedge clk);
    dev_done = 0; bus_rd = 0; m_irq = 0;
    chk(irq == 1'b0, "R9", irq, 0);
    // R10: status load and accepted command together keep BSY
    @(negedge clk);
    dev_status_we = 1; dev_status_in = 8'h41; bus_wr = 1;
    bus_addr = ADDR_W'(7); bus_wdata = 32'h20;
    @(negedge clk);
    dev_status_we = 0; bus_wr = 0; m_stat = 8'hC1;
    chk(tf_status == 8'hC1, "R10", tf_status, 8'hC1);
    chk(cmd_valid == 1'b1 && cmd_opcode == 8'h20, "R5", {cmd_valid, cmd_opcode}, 9'h120);
    dev_evt(0, 1, 8'h00);
    // R8 scratch and unused
    do_wr(10, 32'hFFFF_FF5A);
    do_rd(10);
    do_wr(14, 32'h0000_0099);
    do_rd(14);
    pio_rdata = 32'hDEAD_BEEF;
    do_rd(0);
    do_wr(0, 32'h1357_9BDF);

    // Random phase
    for (int n = 0; n < 800; n++) begin
      int r = $urandom % 10;
      if ($urandom % 4 == 0) begin
        dev_error = 8'($urandom); dev_disc = 8'($urandom); pio_rdata = $urandom;
      end
      if (r < 4)      do_wr($urandom % 16, $urandom);
      else if (r < 8) do_rd($urandom % 16);
      else if (r == 8) dev_evt($urandom % 2, $urandom % 2, 8'($urandom));
      else            dev_evt($urandom % 2, 1, {1'b0, 7'($urandom)});
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule